// File: doc/BRIEF.md
# Scatter-Gather Descriptor Walker

This block drives one DMA channel by walking a linked list of descriptors in memory. Each descriptor is 32 bytes and 32-byte aligned. It names a host buffer address, a local word and a byte count. It also holds a next-pointer pair, whose low word carries three flag bits: end of chain, interrupt request and direction. The engine reads each descriptor word by word over a simple read port. For every descriptor it offers one transfer command on a valid/ready output. It then follows the next pointer, so a chain may be linear or may close on itself as a ring.

Software loads a start pointer and kicks the engine through a small register window. It then polls a done flag or waits for the interrupt line. A run ends when a descriptor marked end of chain has its command accepted, or when an abort written during the run takes effect at the next safe point. A completed descriptor that asks for an interrupt latches a write-1-to-clear status bit. A byte counter sums the counts of all accepted commands since the last start.

Register offsets, all 32-bit words:

| Offset | Register |
|---|---|
| 0x04 | capability |
| 0x10 | start pointer, low word |
| 0x14 | start pointer, high word |
| 0x20 | control/status |
| 0x24 | bytes moved |

Top module: `sgdma_desc_engine`

## Requirements
- R1: After reset the control/status word reads 0x0002_0010 with the default parameters. That is: done (bit 4) set, busy (bit 1), abort-pending (bit 2) and interrupt (bit 5) clear, and DIR_CAP in bits [17:16]. The byte counter reads 0, `irq` is low, and neither `mem_req` nor `cmd_valid` is asserted.
- R2: A run starts only on a control/status write that sets enable (bit 0), start (bit 1) and scatter-gather mode (bit 8) together while idle. A write with start but without mode issues no memory read and leaves done set.
- R3: A descriptor is fetched as eight consecutive word reads at pointer+0, +4, … +28, in this order: host low, host high, local, reserved, count, reserved, next low, next high. Bits [4:0] of the written pointer are ignored, and the pointer reads back with them as zero.
- R4: Only after all eight words arrive is one command offered. The host address is {host high, host low}, the local word and count come straight from the descriptor, and `cmd_to_host` is bit 3 of next low. No memory read is issued while a command is pending.
- R5: The next descriptor address is {next high, next low[31:5], 5'b0}. Bits 0 and 4 of next low have no effect.
- R6: When a descriptor with end of chain (bit 1 of next low) has its command accepted, done is set in that cycle and the engine goes idle.
- R7: A chain whose last next pointer returns to an earlier descriptor is walked repeatedly, one command per descriptor, for as long as no end of chain or abort occurs.
- R8: Writing abort (bit 2) during a run marks the abort as pending. It takes effect after the pending command is accepted, or on the next cycle if the engine is fetching. Done is then set and no further command or read is issued. Writing abort while done is set has no effect, and a later start runs normally.
- R9: Accepting a command whose descriptor has interrupt enable (bit 2 of next low) sets status bit 5 and `irq`. Writing 1 to bit 5 clears it; writing 0 leaves it set.
- R10: The byte counter is cleared by a start and grows by the count of each command in the cycle that command is accepted.
- R11: While `cmd_valid` is high and `cmd_ready` low, the command stays valid and all its fields stay unchanged.
- R12: The capability word has bits [3:0] = 1 (one channel), bit 8 = host addresses wider than 32 bits, and bit 9 = LOCAL_64. Control/status bit 18 reports IS_FIFO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational on `reg_addr` |
| mem_req | output | 1 | Descriptor word read request |
| mem_addr | output | ADDR_W | Byte address of the requested word |
| mem_rvalid | input | 1 | Read data returned this cycle; completes the request |
| mem_rdata | input | 32 | Read data word |
| cmd_valid | output | 1 | Transfer command offered |
| cmd_ready | input | 1 | Transfer command taken |
| cmd_host_addr | output | ADDR_W | Host buffer address |
| cmd_local | output | 32 | Local word from the descriptor |
| cmd_bytes | output | 32 | Byte count |
| cmd_to_host | output | 1 | 1 = write toward host, 0 = read from host |
| irq | output | 1 | Scatter-gather interrupt |

## Verification
The bench builds the block with ADDR_W = 64, CNT_W = 32, LOCAL_64 = 0, DIR_CAP = 2 and IS_FIFO = 0. The 64-bit setting selects the variant that keeps the high pointer words. This lets the bench plant a nonzero next-high word and see it appear on the upper half of the read address, and return a full 64-bit host address in a command. A table of four linked descriptors covers both directions, an ignored flag bit, a mid-chain interrupt and an end-of-chain stop. A two-entry ring then covers wrap-around, abort while a command is pending, abort while fetching and abort while already done.

// File: rtl/sgdma_pkg.sv
`timescale 1ns/1ps
package sgdma_pkg;
   // register window offsets
   localparam logic [7:0] OFS_CAP    = 8'h04;
   localparam logic [7:0] OFS_PTR_LO = 8'h10;
   localparam logic [7:0] OFS_PTR_HI = 8'h14;
   localparam logic [7:0] OFS_CSR    = 8'h20;
   localparam logic [7:0] OFS_XFER   = 8'h24;

   // control/status bit positions
   localparam int CSR_EN   = 0;
   localparam int CSR_GO   = 1;
   localparam int CSR_ABT  = 2;
   localparam int CSR_DONE = 4;
   localparam int CSR_SGI  = 5;
   localparam int CSR_SGM  = 8;
   localparam int CSR_EVE  = 10;
   localparam int CSR_DIR  = 16;
   localparam int CSR_FIFO = 18;

   // flag bits in the low next-pointer word
   localparam int NXT_EOC = 1;
   localparam int NXT_IE  = 2;
   localparam int NXT_DIR = 3;

   localparam int DESC_WORDS = 8;
   localparam int GRAN_LSB   = 5;

   typedef enum logic [1:0] {WK_IDLE, WK_FETCH, WK_CMD} walk_state_e;
endpackage

// File: rtl/sgdma_regs.sv
`timescale 1ns/1ps
module sgdma_regs
   import sgdma_pkg::*;
#(
   parameter int ADDR_W   = 64,
   parameter int CNT_W    = 32,
   parameter int LOCAL_64 = 0,
   parameter int DIR_CAP  = 2,
   parameter int IS_FIFO  = 0
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  reg_we,
   input  logic [7:0]            reg_addr,
   input  logic [31:0]           reg_wdata,
   output logic [31:0]           reg_rdata,
   input  logic                  busy,
   input  logic                  abort_pend,
   input  logic                  fin,
   input  logic                  acc,
   input  logic                  acc_ie,
   input  logic [31:0]           acc_bytes,
   output logic                  start_go,
   output logic                  abort_go,
   output logic [ADDR_W-GRAN_LSB-1:0] start_gran,
   output logic                  done,
   output logic [CNT_W-1:0]      xfer_cnt,
   output logic                  sg_irq
);
   logic [31-GRAN_LSB:0] ptr_lo_q;
   logic [31:0]          hi_rd;
   logic                 en_q, sgm_q, eve_q;
   logic                 csr_wr;

   assign csr_wr   = reg_we && (reg_addr == OFS_CSR);
   assign start_go = csr_wr && reg_wdata[CSR_EN] && reg_wdata[CSR_GO]
                     && reg_wdata[CSR_SGM] && !busy;
   assign abort_go = csr_wr && reg_wdata[CSR_ABT] && busy && !done;

   generate
      if (ADDR_W > 32) begin : g_wide
         logic [31:0] ptr_hi_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               ptr_hi_q <= '0;
            else if (reg_we && (reg_addr == OFS_PTR_HI))
               ptr_hi_q <= reg_wdata;
         end
         assign start_gran = {ptr_hi_q[ADDR_W-33:0], ptr_lo_q};
         assign hi_rd      = ptr_hi_q;
      end else begin : g_narrow
         assign start_gran = ptr_lo_q;
         assign hi_rd      = '0;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_lo_q <= '0;
         en_q     <= 1'b0;
         sgm_q    <= 1'b0;
         eve_q    <= 1'b0;
         done     <= 1'b1;
         sg_irq   <= 1'b0;
         xfer_cnt <= '0;
      end else begin
         if (reg_we && (reg_addr == OFS_PTR_LO))
            ptr_lo_q <= reg_wdata[31:GRAN_LSB];
         if (csr_wr) begin
            en_q  <= reg_wdata[CSR_EN];
            sgm_q <= reg_wdata[CSR_SGM];
            eve_q <= reg_wdata[CSR_EVE];
         end
         if (start_go)
            done <= 1'b0;
         else if (fin)
            done <= 1'b1;
         if (acc && acc_ie)
            sg_irq <= 1'b1;
         else if (csr_wr && reg_wdata[CSR_SGI])
            sg_irq <= 1'b0;
         if (start_go)
            xfer_cnt <= '0;
         else if (acc)
            xfer_cnt <= xfer_cnt + acc_bytes[CNT_W-1:0];
      end
   end

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         OFS_CAP: begin
            reg_rdata[3:0] = 4'd1;
            reg_rdata[8]   = (ADDR_W > 32);
            reg_rdata[9]   = (LOCAL_64 != 0);
         end
         OFS_PTR_LO: reg_rdata[31:GRAN_LSB] = ptr_lo_q;
         OFS_PTR_HI: reg_rdata = hi_rd;
         OFS_CSR: begin
            reg_rdata[CSR_EN]           = en_q;
            reg_rdata[CSR_GO]           = busy;
            reg_rdata[CSR_ABT]          = abort_pend;
            reg_rdata[CSR_DONE]         = done;
            reg_rdata[CSR_SGI]          = sg_irq;
            reg_rdata[CSR_SGM]          = sgm_q;
            reg_rdata[CSR_EVE]          = eve_q;
            reg_rdata[CSR_DIR+1:CSR_DIR] = 2'(DIR_CAP);
            reg_rdata[CSR_FIFO]         = (IS_FIFO != 0);
         end
         OFS_XFER: reg_rdata[CNT_W-1:0] = xfer_cnt;
         default: reg_rdata = '0;
      endcase
   end
endmodule

// File: rtl/sgdma_walker.sv
`timescale 1ns/1ps
module sgdma_walker
   import sgdma_pkg::*;
#(
   parameter int ADDR_W = 64
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       start_go,
   input  logic                       abort_go,
   input  logic [ADDR_W-GRAN_LSB-1:0] start_gran,
   output logic                       mem_req,
   output logic [ADDR_W-1:0]          mem_addr,
   input  logic                       mem_rvalid,
   input  logic [31:0]                mem_rdata,
   output logic                       cmd_valid,
   input  logic                       cmd_ready,
   output logic [ADDR_W-1:0]          cmd_host_addr,
   output logic [31:0]                cmd_local,
   output logic [31:0]                cmd_bytes,
   output logic                       cmd_to_host,
   output logic                       busy,
   output logic                       abort_pend,
   output logic                       fin,
   output logic                       acc,
   output logic                       acc_ie
);
   localparam int GW     = ADDR_W - GRAN_LSB;
   localparam int WIDX_W = $clog2(DESC_WORDS);
   localparam logic [WIDX_W-1:0] WIDX_LAST = WIDX_W'(DESC_WORDS - 1);

   walk_state_e       st;
   logic [WIDX_W-1:0] widx;
   logic [GW-1:0]     cur, nxt;
   logic [31:0]       h_lo, h_hi, n_hi;
   logic [31-GRAN_LSB:0] n_lo;
   logic              f_eoc, f_ie, f_dir, hs;

   generate
      if (ADDR_W > 32) begin : g_wide
         assign cmd_host_addr = {h_hi[ADDR_W-33:0], h_lo};
         assign nxt           = {n_hi[ADDR_W-33:0], n_lo};
      end else begin : g_narrow
         assign cmd_host_addr = h_lo;
         assign nxt           = n_lo;
      end
   endgenerate

   assign busy        = (st != WK_IDLE);
   assign mem_req     = (st == WK_FETCH) && !abort_pend;
   assign mem_addr    = {cur, widx, 2'b00};
   assign hs          = mem_req && mem_rvalid;
   assign cmd_valid   = (st == WK_CMD);
   assign cmd_to_host = f_dir;
   assign acc         = cmd_valid && cmd_ready;
   assign acc_ie      = f_ie;
   assign fin         = ((st == WK_FETCH) && abort_pend) ||
                        (acc && (f_eoc || abort_pend));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st         <= WK_IDLE;
         widx       <= '0;
         cur        <= '0;
         abort_pend <= 1'b0;
         h_lo <= '0; h_hi <= '0; n_hi <= '0; n_lo <= '0;
         cmd_local <= '0; cmd_bytes <= '0;
         f_eoc <= 1'b0; f_ie <= 1'b0; f_dir <= 1'b0;
      end else begin
         abort_pend <= fin ? 1'b0 : (abort_pend | abort_go);
         case (st)
            WK_IDLE: if (start_go) begin
               cur  <= start_gran;
               widx <= '0;
               st   <= WK_FETCH;
            end
            WK_FETCH: if (abort_pend) begin
               st <= WK_IDLE;
            end else if (hs) begin
               case (widx)
                  3'd0: h_lo      <= mem_rdata;
                  3'd1: h_hi      <= mem_rdata;
                  3'd2: cmd_local <= mem_rdata;
                  3'd4: cmd_bytes <= mem_rdata;
                  3'd6: begin
                     n_lo  <= mem_rdata[31:GRAN_LSB];
                     f_eoc <= mem_rdata[NXT_EOC];
                     f_ie  <= mem_rdata[NXT_IE];
                     f_dir <= mem_rdata[NXT_DIR];
                  end
                  3'd7: n_hi      <= mem_rdata;
                  default: ;
               endcase
               widx <= widx + 1'b1;
               if (widx == WIDX_LAST) st <= WK_CMD;
            end
            WK_CMD: if (cmd_ready) begin
               if (f_eoc || abort_pend) begin
                  st <= WK_IDLE;
               end else begin
                  cur  <= nxt;
                  widx <= '0;
                  st   <= WK_FETCH;
               end
            end
            default: st <= WK_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/sgdma_desc_engine.sv
`timescale 1ns/1ps
module sgdma_desc_engine
   import sgdma_pkg::*;
#(
   parameter int ADDR_W   = 64,
   parameter int CNT_W    = 32,
   parameter int LOCAL_64 = 0,
   parameter int DIR_CAP  = 2,
   parameter int IS_FIFO  = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [7:0]        reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   output logic              mem_req,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic              mem_rvalid,
   input  logic [31:0]       mem_rdata,
   output logic              cmd_valid,
   input  logic              cmd_ready,
   output logic [ADDR_W-1:0] cmd_host_addr,
   output logic [31:0]       cmd_local,
   output logic [31:0]       cmd_bytes,
   output logic              cmd_to_host,
   output logic              irq
);
   generate
      if (ADDR_W < 32 || ADDR_W > 64) begin : g_bad_addr_w
         $error("ADDR_W must lie in 32..64");
      end
      if (CNT_W < 8 || CNT_W > 32) begin : g_bad_cnt_w
         $error("CNT_W must lie in 8..32");
      end
      if (DIR_CAP < 0 || DIR_CAP > 2) begin : g_bad_dir
         $error("DIR_CAP must be 0, 1 or 2");
      end
   endgenerate

   logic                        start_go_w, abort_go_w, busy_w, pend_w;
   logic                        fin_w, acc_w, acc_ie_w, done_w;
   logic [ADDR_W-GRAN_LSB-1:0]  gran_w;
   logic [CNT_W-1:0]            xfer_w;

   sgdma_regs #(
      .ADDR_W(ADDR_W), .CNT_W(CNT_W), .LOCAL_64(LOCAL_64),
      .DIR_CAP(DIR_CAP), .IS_FIFO(IS_FIFO)
   ) u_regs (
      .clk(clk), .rst_n(rst_n),
      .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata),
      .busy(busy_w), .abort_pend(pend_w), .fin(fin_w),
      .acc(acc_w), .acc_ie(acc_ie_w), .acc_bytes(cmd_bytes),
      .start_go(start_go_w), .abort_go(abort_go_w), .start_gran(gran_w),
      .done(done_w), .xfer_cnt(xfer_w), .sg_irq(irq)
   );

   sgdma_walker #(.ADDR_W(ADDR_W)) u_walk (
      .clk(clk), .rst_n(rst_n),
      .start_go(start_go_w), .abort_go(abort_go_w), .start_gran(gran_w),
      .mem_req(mem_req), .mem_addr(mem_addr),
      .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
      .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
      .cmd_host_addr(cmd_host_addr), .cmd_local(cmd_local),
      .cmd_bytes(cmd_bytes), .cmd_to_host(cmd_to_host),
      .busy(busy_w), .abort_pend(pend_w), .fin(fin_w),
      .acc(acc_w), .acc_ie(acc_ie_w)
   );
endmodule

// File: rtl/sgdma_chk.sv
`timescale 1ns/1ps
module sgdma_chk #(
   parameter int ADDR_W = 64,
   parameter int CNT_W  = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              mem_req,
   input logic              mem_rvalid,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              cmd_valid,
   input logic              cmd_ready,
   input logic [ADDR_W-1:0] cmd_host_addr,
   input logic [31:0]       cmd_local,
   input logic [31:0]       cmd_bytes,
   input logic              cmd_to_host,
   input logic              irq,
   input logic              done,
   input logic              start_go,
   input logic [CNT_W-1:0]  xfer_cnt
);
   // R11
   cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_host_addr) &&
      $stable(cmd_local) && $stable(cmd_bytes) && $stable(cmd_to_host));

   // R3
   fetch_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && mem_rvalid && (mem_addr[4:2] != 3'd7) |=>
      !mem_req || (mem_addr == $past(mem_addr) + ADDR_W'(4)));

   // R4
   port_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_req && cmd_valid));

   // R6
   done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !mem_req && !cmd_valid);

   // R9
   irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> $past(cmd_valid && cmd_ready));

   // R10
   xfer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(cmd_valid && cmd_ready) && !start_go |=> $stable(xfer_cnt));
endmodule

bind sgdma_desc_engine sgdma_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n),
   .mem_req(mem_req), .mem_rvalid(mem_rvalid), .mem_addr(mem_addr),
   .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
   .cmd_host_addr(cmd_host_addr), .cmd_local(cmd_local),
   .cmd_bytes(cmd_bytes), .cmd_to_host(cmd_to_host),
   .irq(irq), .done(done_w), .start_go(start_go_w), .xfer_cnt(xfer_w)
);

// File: tb/tb_sgdma_desc_engine.sv
`timescale 1ns/1ps
module tb_sgdma_desc_engine;
   localparam int AW = 64;
   localparam int NT = 4;
   // linked table: slots 2..5 (byte 0x40..0xBF)
   localparam logic [31:0] T_HLO [NT] = '{32'h1000_0000, 32'h1000_2000, 32'h2000_0400, 32'h3000_0800};
   localparam logic [31:0] T_HHI [NT] = '{32'h0, 32'h1, 32'h0, 32'h0000_ABCD};
   localparam logic [31:0] T_LOC [NT] = '{32'h1111_1111, 32'h0, 32'h5A5A_0000, 32'h2222_2222};
   localparam logic [31:0] T_BYT [NT] = '{32'h100, 32'h40, 32'h1F0, 32'h8};
   localparam logic [31:0] T_FLG [NT] = '{32'h8, 32'h11, 32'h4, 32'h6};
   localparam logic [31:0] T_NHI [NT] = '{32'h0, 32'h5, 32'h0, 32'h0};

   logic          clk = 1'b0;
   logic          rst_n;
   logic          reg_we;
   logic [7:0]    reg_addr;
   logic [31:0]   reg_wdata, reg_rdata;
   logic          mem_req, mem_rvalid;
   logic [AW-1:0] mem_addr;
   logic [31:0]   mem_rdata;
   logic          cmd_valid, cmd_ready, cmd_to_host, irq;
   logic [AW-1:0] cmd_host_addr;
   logic [31:0]   cmd_local, cmd_bytes;
   logic [31:0]   mem [64];
   int            n_chk = 0, n_bad = 0;

   always #4 clk = ~clk;

   assign mem_rvalid = mem_req;
   assign mem_rdata  = mem[mem_addr[7:2]];

   sgdma_desc_engine #(.ADDR_W(AW), .CNT_W(32), .LOCAL_64(0), .DIR_CAP(2), .IS_FIFO(0)) dut (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
      .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_host_addr(cmd_host_addr),
      .cmd_local(cmd_local), .cmd_bytes(cmd_bytes), .cmd_to_host(cmd_to_host), .irq(irq)
   );

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic put_desc(input int slot, input logic [31:0] hlo, hhi, loc, byt, nlo, nhi);
      mem[slot*8+0] = hlo; mem[slot*8+1] = hhi; mem[slot*8+2] = loc; mem[slot*8+3] = 32'hDEAD_0003;
      mem[slot*8+4] = byt; mem[slot*8+5] = 32'hDEAD_0005; mem[slot*8+6] = nlo; mem[slot*8+7] = nhi;
   endtask

   task automatic wait_cmd();
      for (int n = 0; n < 60 && !cmd_valid; n++) @(negedge clk);
   endtask

   task automatic take_cmd(input logic [63:0] h, input logic [31:0] l, b, input logic d,
                           input int hold, input string tag);
      wait_cmd();
      chk({tag, " valid"}, cmd_valid, 1'b1);
      for (int k = 0; k < hold; k++) begin
         @(negedge clk);
         chk("R11 held command", {cmd_valid, cmd_host_addr[62:0]}, {1'b1, h[62:0]});
         chk("R11 held count", cmd_bytes, b);
      end
      chk({tag, " host"}, cmd_host_addr, h);
      chk({tag, " local"}, cmd_local, l);
      chk({tag, " bytes"}, cmd_bytes, b);
      chk({tag, " dir"}, cmd_to_host, d);
      cmd_ready = 1'b1;
      @(negedge clk);
      cmd_ready = 1'b0;
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog R6 actual=hung expected=finished");
      summary();
   end

   initial begin
      logic [31:0] v;
      logic [31:0] sum;
      rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0; cmd_ready = 1'b0;
      for (int i = 0; i < 64; i++) mem[i] = '0;
      for (int i = 0; i < NT; i++)
         put_desc(2 + i, T_HLO[i], T_HHI[i], T_LOC[i], T_BYT[i],
                  ((i < NT-1) ? 32'h40 + 32'(32*(i+1)) : 32'h0) | T_FLG[i], T_NHI[i]);
      repeat (4) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state, R12 static fields
      rd(8'h20, v); chk("R1 csr reset", v, 32'h0002_0010);
      rd(8'h24, v); chk("R1 bytes reset", v, 32'h0);
      chk("R1 outputs idle", {irq, mem_req, cmd_valid}, 3'b000);
      rd(8'h04, v); chk("R12 capability", v, 32'h0000_0101);

      // R2 start without mode bit is ignored; R3 pointer low bits dropped
      wr(8'h10, 32'h0000_005F);
      wr(8'h14, 32'h0);
      rd(8'h10, v); chk("R3 pointer readback", v, 32'h40);
      wr(8'h20, 32'h0000_0003);
      for (int k = 0; k < 5; k++) begin
         @(negedge clk); chk("R2 no fetch", mem_req, 1'b0);
      end
      rd(8'h20, v); chk("R2 still done", v[4:1], 4'b1000);

      // R3 fetch order
      wr(8'h20, 32'h0000_0103);
      for (int k = 0; k < 8; k++) begin
         chk("R3 word address", {mem_req, mem_addr}, {1'b1, 64'h40 + 64'(4*k)});
         @(negedge clk);
      end

      // table walk: R4 R5 R6 R9 R10
      sum = 0;
      for (int i = 0; i < NT; i++) begin
         take_cmd({T_HHI[i], T_HLO[i]}, T_LOC[i], T_BYT[i], T_FLG[i][3], (i == 0) ? 3 : 0, "R4");
         sum = sum + T_BYT[i];
         if (i == 0) chk("R5 next address", {mem_req, mem_addr}, {1'b1, 64'h60});
         if (i == 1) chk("R5 next high word", {mem_req, mem_addr}, {1'b1, 64'h0000_0005_0000_0080});
         chk("R9 irq level", irq, (i >= 2));
         rd(8'h24, v); chk("R10 running bytes", v, sum);
      end
      rd(8'h20, v); chk("R6 done idle", v[4:1], 4'b1000);
      chk("R6 quiet", {mem_req, cmd_valid}, 2'b00);

      // R9 write-1-to-clear
      wr(8'h20, 32'h0000_0101);
      chk("R9 zero write keeps irq", irq, 1'b1);
      wr(8'h20, 32'h0000_0020);
      chk("R9 clear irq", irq, 1'b0);
      rd(8'h20, v); chk("R9 status bit", v[5], 1'b0);

      // R7 ring of two, R8 abort with command pending
      put_desc(6, 32'h7000_0000, 32'h0, 32'h0, 32'h10, 32'hE0, 32'h0);
      put_desc(7, 32'h7100_0000, 32'h0, 32'h0, 32'h20, 32'hC0, 32'h0);
      wr(8'h10, 32'h0000_00C0);
      wr(8'h20, 32'h0000_0103);
      rd(8'h24, v); chk("R10 cleared on start", v, 32'h0);
      for (int k = 0; k < 5; k++)
         take_cmd((k % 2) ? 64'h7100_0000 : 64'h7000_0000, 32'h0,
                  (k % 2) ? 32'h20 : 32'h10, 1'b0, 0, "R7");
      rd(8'h24, v); chk("R10 ring bytes", v, 32'h70);
      wait_cmd();
      wr(8'h20, 32'h0000_0004);
      rd(8'h20, v); chk("R8 abort pending", v[4:1], 4'b0011);
      take_cmd(64'h7100_0000, 32'h0, 32'h20, 1'b0, 0, "R8 last before abort");
      rd(8'h20, v); chk("R8 done after abort", v[4:1], 4'b1000);
      for (int k = 0; k < 8; k++) begin
         @(negedge clk); chk("R8 stopped", {mem_req, cmd_valid}, 2'b00);
      end

      // R8 abort while done has no effect
      wr(8'h20, 32'h0000_0004);
      rd(8'h20, v); chk("R8 abort while done", v[4:1], 4'b1000);
      wr(8'h20, 32'h0000_0103);
      take_cmd(64'h7000_0000, 32'h0, 32'h10, 1'b0, 0, "R8 restart runs");

      // R8 abort during fetch
      wr(8'h20, 32'h0000_0004);
      for (int k = 0; k < 6; k++) begin
         @(negedge clk); chk("R8 fetch abort no cmd", cmd_valid, 1'b0);
      end
      rd(8'h20, v); chk("R8 fetch abort done", v[4:1], 4'b1000);
      rd(8'h24, v); chk("R10 bytes after abort", v, 32'h10);

      summary();
   end
endmodule